// File: doc/BRIEF.md
# Interrupt Register Bank Sequencer

This block preserves a CPU's working registers across interrupt entry by copying them into a small on-chip bank instead of pushing them to memory. An entry pulse starts a save. The block then walks a register-file read port through five groups. Each group is four registers wide, and the block stores one group per cycle into the current bank slot. A restore command, issued by the service routine just before it returns from the exception, walks the same five groups. It reads them back from the most recently filled slot and drives them onto a register-file write port.

The slots form a stack. A level counter rises after each completed save and falls after each completed restore. While a sequence runs, `busy` stays high. A one-cycle `done` pulse follows, and the fetch unit waits for it before fetching the first handler instruction. A save into a full bank, or a restore from an empty bank, moves no data. It produces an error pulse together with `done`, so a waiting fetch unit is never left hanging. Group index 0 holds the control and MAC registers (vector table base, return address, global base, MAC low). Index 1 holds R12–R14 and MAC high. Indexes 2, 3 and 4 hold R8–R11, R4–R7 and R0–R3.

Top module: `irq_bank_seq`

## Requirements
- R1: After reset, `busy`, `done`, `ovf_err`, `unf_err` and `rf_wr_en` are 0 and `bank_level` is 0.
- R2: A save request sampled while idle and not full raises `busy` for exactly five cycles. During those cycles `rf_rd_grp` shows 0, 1, 2, 3, 4 in order, one value per cycle.
- R3: `done` is high for exactly one cycle. For an accepted sequence, it comes in the cycle right after the last `busy` cycle.
- R4: A completed save stores the five groups present on `rf_rd_data` into slot `bank_level` and raises `bank_level` by one when `done` rises.
- R5: A restore request sampled while idle and not empty holds `busy` and `rf_wr_en` high for five cycles. During those cycles `rf_wr_grp` shows 0 to 4 in order and `rf_wr_data` carries the groups of slot `bank_level`-1. `bank_level` falls by one, so save then restore returns every register exactly, last saved first restored.
- R6: A save request while `bank_level` equals SLOTS gives `done` and `ovf_err` for one cycle, one cycle later, with no `busy`. `bank_level` is unchanged and no slot is overwritten.
- R7: A restore request while `bank_level` is 0 gives `done` and `unf_err` for one cycle, one cycle later, with no `busy` and no register-file write.
- R8: Save or restore requests sampled while `busy` is high are ignored. They start no further sequence and change neither the level nor the stored data.
- R9: When save and restore requests are sampled together while idle, the save is taken.
- R10: `rf_wr_en` is never high outside a restore sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| save_req | input | 1 | Interrupt-entry save request |
| restore_req | input | 1 | Restore-from-bank command |
| rf_rd_grp | output | $clog2(GROUPS) | Register group being read during a save |
| rf_rd_data | input | DATA_W*LANES | Register group contents from the register file |
| rf_wr_en | output | 1 | Register-file write strobe during a restore |
| rf_wr_grp | output | $clog2(GROUPS) | Register group being written |
| rf_wr_data | output | DATA_W*LANES | Restored group contents |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf_err | output | 1 | Save rejected, bank full |
| unf_err | output | 1 | Restore rejected, bank empty |
| bank_level | output | $clog2(SLOTS+1) | Number of filled slots |

## Verification
The bench builds the block with DATA_W=16 and SLOTS=3, keeping GROUPS=5 and LANES=4. With only three slots, random save and restore mixes hit both the full and the empty bank often. They also hit stacked saves several deep, which checks the last-in first-out order. The narrow data width keeps each group at 64 bits, so a bench register-file model can compare every restored group exactly.

// File: rtl/irq_bank_seq.sv
module irq_bank_seq #(
  parameter int DATA_W = 32,
  parameter int SLOTS  = 4,
  parameter int GROUPS = 5,
  parameter int LANES  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        save_req,
  input  logic                        restore_req,
  output logic [$clog2(GROUPS)-1:0]   rf_rd_grp,
  input  logic [DATA_W*LANES-1:0]     rf_rd_data,
  output logic                        rf_wr_en,
  output logic [$clog2(GROUPS)-1:0]   rf_wr_grp,
  output logic [DATA_W*LANES-1:0]     rf_wr_data,
  output logic                        busy,
  output logic                        done,
  output logic                        ovf_err,
  output logic                        unf_err,
  output logic [$clog2(SLOTS+1)-1:0]  bank_level
);
  localparam int GW     = DATA_W * LANES;
  localparam int STEP_W = $clog2(GROUPS);
  localparam int LVL_W  = $clog2(SLOTS + 1);
  localparam int IDX_W  = $clog2(SLOTS * GROUPS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(GROUPS - 1);
  localparam logic [LVL_W-1:0]  FULL = LVL_W'(SLOTS);

  logic [GW-1:0]     bank [SLOTS*GROUPS];
  logic              busy_q, rest_q, done_q, ovf_q, unf_q;
  logic [STEP_W-1:0] step_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [LVL_W-1:0]  slot;
  logic [IDX_W-1:0]  idx;

  assign slot = rest_q ? lvl_q - 1'b1 : lvl_q;
  assign idx  = IDX_W'(int'(slot) * GROUPS + int'(step_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rest_q <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      step_q <= '0;
      lvl_q  <= '0;
    end else begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      if (busy_q) begin
        if (step_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          lvl_q  <= rest_q ? lvl_q - 1'b1 : lvl_q + 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else if (save_req) begin
        if (lvl_q == FULL) begin
          done_q <= 1'b1;
          ovf_q  <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          rest_q <= 1'b0;
          step_q <= '0;
        end
      end else if (restore_req) begin
        if (lvl_q == '0) begin
          done_q <= 1'b1;
          unf_q  <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          rest_q <= 1'b1;
          step_q <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q && !rest_q) bank[idx] <= rf_rd_data;
  end

  assign rf_rd_grp  = step_q;
  assign rf_wr_grp  = step_q;
  assign rf_wr_en   = busy_q & rest_q;
  assign rf_wr_data = bank[idx];
  assign busy       = busy_q;
  assign done       = done_q;
  assign ovf_err    = ovf_q;
  assign unf_err    = unf_q;
  assign bank_level = lvl_q;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $past(!rst_n) |-> (bank_level == '0)); // R1
  AST_BUSY_RUNS: assert property (@(posedge clk) disable iff (!rst_n) (busy && rf_rd_grp != LAST) |=> busy); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (done && !ovf_err && !unf_err) |-> $past(busy)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_LEVEL_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) (bank_level != $past(bank_level)) |-> (done && !ovf_err && !unf_err)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) ovf_err |-> (bank_level == FULL && $stable(bank_level) && !busy)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) unf_err |-> (bank_level == '0 && !rf_wr_en)); // R7
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) bank_level <= FULL); // R6
endmodule

// File: tb/irq_bank_seq_test.sv
module irq_bank_seq_test;
  localparam int CLK_NS = 10;
  localparam int DW = 16;
  localparam int NS = 3;
  localparam int NG = 5;
  localparam int GW = DW * 4;

  logic clk = 0, rst_n = 0, save_req = 0, restore_req = 0;
  logic [2:0] rd_grp, wr_grp;
  logic [GW-1:0] rd_data, wr_data;
  logic wr_en, busy, done, ovf, unf;
  logic [1:0] level;

  logic [GW-1:0] rf [NG];
  logic [GW-1:0] ldv [NG];
  logic ld = 0;
  logic [GW-1:0] stk [NS][NG];
  int sp = 0;
  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  irq_bank_seq #(.DATA_W(DW), .SLOTS(NS), .GROUPS(NG), .LANES(4)) uut (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .rf_rd_grp(rd_grp), .rf_rd_data(rd_data), .rf_wr_en(wr_en), .rf_wr_grp(wr_grp),
    .rf_wr_data(wr_data), .busy(busy), .done(done), .ovf_err(ovf), .unf_err(unf),
    .bank_level(level));

  assign rd_data = rf[rd_grp];

  always @(posedge clk) begin
    if (ld) begin
      for (int g = 0; g < NG; g++) rf[g] <= ldv[g];
    end else if (wr_en) rf[wr_grp] <= wr_data;
  end

  task automatic chk(input string r, input logic [GW-1:0] act, input logic [GW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic scramble();
    for (int g = 0; g < NG; g++) ldv[g] = {$urandom, $urandom};
    ld = 1;
    @(negedge clk);
    ld = 0;
  endtask

  task automatic do_save(input bit poke, input bit both);
    save_req = 1;
    restore_req = both;
    @(negedge clk);
    save_req = 0;
    restore_req = 0;
    if (sp == NS) begin
      chk("R6 busy", busy, 0);
      chk("R6 done", done, 1);
      chk("R6 ovf", ovf, 1);
      chk("R6 level", level, NS);
      @(negedge clk);
      chk("R3 done single", done, 0);
    end else begin
      for (int k = 0; k < NG; k++) begin
        chk("R2 busy", busy, 1);
        chk("R2 grp order", rd_grp, k);
        chk(both ? "R9 save wins" : "R10 no write in save", wr_en, 0);
        if (poke && k == 2) begin save_req = 1; restore_req = 1; end
        if (poke && k == 3) begin save_req = 0; restore_req = 0; end
        @(negedge clk);
      end
      chk("R3 done", done, 1);
      chk("R3 busy low", busy, 0);
      chk("R4 level", level, sp + 1);
      for (int g = 0; g < NG; g++) stk[sp][g] = rf[g];
      sp++;
      @(negedge clk);
      chk("R3 done single", done, 0);
      chk("R8 no new sequence", busy, 0);
      chk("R8 level kept", level, sp);
    end
  endtask

  task automatic do_restore();
    logic [GW-1:0] snap [NG];
    for (int g = 0; g < NG; g++) snap[g] = rf[g];
    restore_req = 1;
    @(negedge clk);
    restore_req = 0;
    if (sp == 0) begin
      chk("R7 busy", busy, 0);
      chk("R7 done", done, 1);
      chk("R7 unf", unf, 1);
      chk("R7 no write", wr_en, 0);
      @(negedge clk);
      for (int g = 0; g < NG; g++) chk("R7 regs unchanged", rf[g], snap[g]);
      chk("R7 level", level, 0);
    end else begin
      for (int k = 0; k < NG; k++) begin
        chk("R5 busy", busy, 1);
        chk("R5 wr_en", wr_en, 1);
        chk("R5 grp order", wr_grp, k);
        @(negedge clk);
      end
      chk("R3 done", done, 1);
      chk("R10 wr_en off", wr_en, 0);
      sp--;
      chk("R5 level", level, sp);
      for (int g = 0; g < NG; g++) chk("R5 roundtrip", rf[g], stk[sp][g]);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int g = 0; g < NG; g++) ldv[g] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 level", level, 0);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 errs", {ovf, unf}, 0);
    rst_n = 1;
    scramble();
    do_restore();
    scramble(); do_save(0, 0);
    scramble(); do_save(1, 0);
    scramble(); do_save(0, 1);
    scramble(); do_save(0, 0);
    scramble(); do_save(1, 0);
    repeat (3) begin scramble(); do_restore(); end
    do_restore();
    repeat (150) begin
      scramble();
      case ($urandom % 4)
        0: do_save(0, 0);
        1: do_save(1, ($urandom % 2) == 1);
        default: do_restore();
      endcase
    end
    while (sp > 0) begin scramble(); do_restore(); end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule